// File: doc/BRIEF.md
# Converter Control Register and Power Sequencer

This block sits in front of an analog converter core. Software sees one 8-bit control register through a plain write/read port. The register holds four fields: an enable, a self-clearing reset request, a keep-running-in-standby option and an analog-power-on-demand option. From these fields and a few status inputs, the block decides three things:

- when the analog front end is powered;
- when a conversion is started;
- whether the main clock must be requested while the chip is asleep.

It also acknowledges standby requests. It drives a reset strobe that returns the peripheral's other registers to their reset values.

Analog power has two modes. In continuous mode it follows the enable and input-selected signals, which keeps start-up latency short. In on-demand mode it is raised only when a conversion is triggered, and the start strobe waits a parameterized number of settling cycles. If the keep-running option is clear, standby entry is held off until any ongoing conversion ends. If it is set, the block keeps converting while asleep and requests the main clock for each conversion.

Top module: `adc_pwr_seq`

## Requirements
- R1: After reset, the register reads 0x00, and analog enable, conversion start, clock request, standby acknowledge, busy and peripheral reset are all low.
- R2: The register has the following field positions:
  - bit 7: on-demand;
  - bit 6: keep-running-in-standby;
  - bit 1: enable;
  - bit 0: reset request.
  All other read bits are 0. A write with bit 0 clear stores bits 7, 6 and 1 on the next edge.
- R3: A write with bit 0 set clears every field and discards the other written bits. Read bit 0, sync_busy and periph_rst are then high for exactly SRST_CYC cycles (default 2), after which they clear.
- R4: A write with bit 0 clear never starts the reset sequence: sync_busy stays low.
- R5: A write while lock is high changes nothing.
- R6: A write during the reset sequence is ignored.
- R7: With on-demand clear, ana_en equals enable AND inp_sel, one cycle after they are sampled.
- R8: With on-demand set, ana_en is low while idle. It rises on the edge that accepts a trigger. conv_start is a single-cycle pulse SETTLE_CYC cycles after ana_en rises. ana_en falls on the edge that samples conv_done.
- R9: With on-demand clear, conv_start pulses for one cycle on the edge after a trigger is accepted.
- R10: A trigger is ignored while the block is disabled or while a conversion is in progress.
- R11: With keep-running clear, stby_ack is withheld while a conversion is in progress and rises on the edge that samples conv_done. While it is asserted, triggers are ignored.
- R12: With keep-running set, stby_ack follows stby_req. During standby, clk_req is high from the accepted trigger until the edge sampling conv_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| lock | input | 1 | Write protection; writes ignored while high |
| rd_data | output | 8 | Register read value |
| sync_busy | output | 1 | Reset sequence in progress |
| periph_rst | output | 1 | Reset strobe to other peripheral registers |
| trig | input | 1 | Conversion trigger |
| conv_done | input | 1 | Conversion finished pulse from core |
| inp_sel | input | 1 | An analog input is selected |
| stby_req | input | 1 | Standby entry request |
| ana_en | output | 1 | Analog front-end power enable |
| conv_start | output | 1 | Conversion start strobe |
| clk_req | output | 1 | Main clock request during standby |
| stby_ack | output | 1 | Standby entry acknowledge |

## Verification
The hardest case to reach from the ports is a standby request that arrives in the middle of a conversion with keep-running clear. Reaching it needs a specific order of events: a trigger is accepted, then the standby request is raised while conv_done is held off, then conv_done is pulsed. The directed stimulus builds exactly that order and checks that the acknowledge stays low until the done edge. A second directed case then checks that a trigger is rejected while the acknowledge is held. Random write, lock and input patterns then exercise the register path and the continuous power mode against a bench model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int BIT_ODM  = 7;
   localparam int BIT_RSB  = 6;
   localparam int BIT_ENA  = 1;
   localparam int BIT_SRST = 0;

   typedef enum logic [1:0] {ST_IDLE, ST_SETTLE, ST_CONV} seq_state_e;

   typedef struct packed {
      logic odm;
      logic rsb;
      logic ena;
   } ctrl_fields_t;
endpackage

// File: rtl/adc_ctrl_reg.sv
module adc_ctrl_reg
   import adc_seq_pkg::*;
#(
   parameter int SRST_CYC = 2,
   parameter int DW       = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          lock,
   output logic [DW-1:0] rd_data,
   output ctrl_fields_t  fields,
   output logic          busy
);
   localparam int CW = $clog2(SRST_CYC + 1);

   if (SRST_CYC < 1) begin : g_bad_srst
      $error("SRST_CYC must be at least 1");
   end
   if (DW != 8) begin : g_bad_dw
      $error("DW must be 8");
   end

   ctrl_fields_t fields_q;
   logic         accept;
   logic         srst_hit;

   assign accept   = wr_en && !lock && !busy;
   assign srst_hit = accept && wr_data[BIT_SRST];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fields_q <= '0;
      end else if (srst_hit) begin
         fields_q <= '0;
      end else if (accept) begin
         fields_q.odm <= wr_data[BIT_ODM];
         fields_q.rsb <= wr_data[BIT_RSB];
         fields_q.ena <= wr_data[BIT_ENA];
      end
   end

   if (SRST_CYC == 1) begin : g_busy_flop
      logic busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= srst_hit;
      end
      assign busy = busy_q;
   end else begin : g_busy_cnt
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         else if (srst_hit)     cnt_q <= CW'(SRST_CYC);
      end
      assign busy = (cnt_q != '0);
   end

   assign fields = fields_q;

   always_comb begin
      rd_data           = '0;
      rd_data[BIT_ODM]  = fields_q.odm;
      rd_data[BIT_RSB]  = fields_q.rsb;
      rd_data[BIT_ENA]  = fields_q.ena;
      rd_data[BIT_SRST] = busy;
   end

   assert_busy_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (fields_q == '0));
   assert_lock_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(fields_q));
   assert_busy_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(fields_q));
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int SETTLE_CYC = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  ctrl_fields_t cfg,
   input  logic         busy,
   input  logic         trig,
   input  logic         conv_done,
   input  logic         inp_sel,
   input  logic         stby_req,
   output logic         ana_en,
   output logic         conv_start,
   output logic         clk_req,
   output logic         stby_ack
);
   localparam int SW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("SETTLE_CYC must be at least 1");
   end

   seq_state_e st_q, st_d;
   logic [SW-1:0] cnt_q;
   logic go, settle_end;
   logic ana_q, start_q, creq_q, ack_q;

   assign go         = trig && cfg.ena && !busy && (st_q == ST_IDLE) && !(ack_q && !cfg.rsb);
   assign settle_end = (st_q == ST_SETTLE) && (cnt_q == '0);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (go) st_d = cfg.odm ? ST_SETTLE : ST_CONV;
         ST_SETTLE: if (cnt_q == '0) st_d = ST_CONV;
         ST_CONV:   if (conv_done) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
      if (!cfg.ena || busy) st_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         cnt_q   <= '0;
         ana_q   <= 1'b0;
         start_q <= 1'b0;
         creq_q  <= 1'b0;
         ack_q   <= 1'b0;
      end else begin
         st_q <= st_d;
         if (go)                      cnt_q <= SW'(SETTLE_CYC - 1);
         else if (st_q == ST_SETTLE)  cnt_q <= cnt_q - 1'b1;
         start_q <= (go && !cfg.odm) || (settle_end && cfg.ena && !busy);
         ana_q   <= cfg.odm ? (st_d != ST_IDLE) : (cfg.ena && inp_sel);
         creq_q  <= stby_req && cfg.rsb && (st_d != ST_IDLE);
         ack_q   <= stby_req && (cfg.rsb || st_d == ST_IDLE);
      end
   end

   assign ana_en     = ana_q;
   assign conv_start = start_q;
   assign clk_req    = creq_q;
   assign stby_ack   = ack_q;

   assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);
   assert_start_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (conv_start && cfg.odm) |-> ana_en);
   assert_disabled_trig_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg.ena |=> !conv_start);
   assert_stby_wait_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (stby_ack && !cfg.rsb) |-> (st_q == ST_IDLE));
   assert_clkreq_R12: assert property (@(posedge clk) disable iff (!rst_n)
      clk_req |-> $past(stby_req));
endmodule

// File: rtl/adc_pwr_seq.sv
module adc_pwr_seq
   import adc_seq_pkg::*;
#(
   parameter int SRST_CYC   = 2,
   parameter int SETTLE_CYC = 3,
   parameter int DW         = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          lock,
   output logic [DW-1:0] rd_data,
   output logic          sync_busy,
   output logic          periph_rst,
   input  logic          trig,
   input  logic          conv_done,
   input  logic          inp_sel,
   input  logic          stby_req,
   output logic          ana_en,
   output logic          conv_start,
   output logic          clk_req,
   output logic          stby_ack
);
   ctrl_fields_t fields;
   logic         busy;

   adc_ctrl_reg #(.SRST_CYC(SRST_CYC), .DW(DW)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .lock    (lock),
      .rd_data (rd_data),
      .fields  (fields),
      .busy    (busy)
   );

   adc_seq_fsm #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg        (fields),
      .busy       (busy),
      .trig       (trig),
      .conv_done  (conv_done),
      .inp_sel    (inp_sel),
      .stby_req   (stby_req),
      .ana_en     (ana_en),
      .conv_start (conv_start),
      .clk_req    (clk_req),
      .stby_ack   (stby_ack)
   );

   assign sync_busy  = busy;
   assign periph_rst = busy;

   assert_rdbit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sync_busy |-> (rd_data == 8'h01));
endmodule

// File: tb/tb_adc_pwr_seq.sv
module tb_adc_pwr_seq;
   localparam int CLK_PERIOD = 10;
   localparam int SRST = 2;
   localparam int SETTLE = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, lock = 1'b0, trig = 1'b0, conv_done = 1'b0;
   logic inp_sel = 1'b0, stby_req = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic sync_busy, periph_rst, ana_en, conv_start, clk_req, stby_ack;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_pwr_seq #(.SRST_CYC(SRST), .SETTLE_CYC(SETTLE)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .lock(lock),
      .rd_data(rd_data), .sync_busy(sync_busy), .periph_rst(periph_rst),
      .trig(trig), .conv_done(conv_done), .inp_sel(inp_sel), .stby_req(stby_req),
      .ana_en(ana_en), .conv_start(conv_start), .clk_req(clk_req), .stby_ack(stby_ack)
   );

   task automatic check(input string req, input string what, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s %s: got 0x%0h expected 0x%0h", req, what, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] d);
      wr_en = 1'b1; wr_data = d;
      step();
      wr_en = 1'b0; wr_data = '0;
   endtask

   function automatic logic [7:0] exp_read(input logic [7:0] f, input bit b);
      return (f & 8'hC2) | {7'd0, b};
   endfunction

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] mf;
      int bcnt;
      void'($urandom(32'h5eed_1234));
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      check("R1", "rd_data", rd_data, 8'h00);
      check("R1", "outputs", {ana_en, conv_start, clk_req, stby_ack, sync_busy, periph_rst}, 0);

      // R2/R4 field store, bit0 clear
      wr(8'hFE);
      check("R2", "readback", rd_data, 8'hC2);
      check("R4", "no busy", sync_busy, 0);

      // R3 reset request discards other bits
      wr(8'hC3);
      check("R3", "rd during reset", rd_data, 8'h01);
      check("R3", "busy/prst c1", {sync_busy, periph_rst}, 2'b11);
      step();
      check("R3", "busy c2", sync_busy, 1);
      step();
      check("R3", "busy cleared", {sync_busy, periph_rst}, 0);
      check("R3", "fields cleared", rd_data, 8'h00);

      // R6 write during reset sequence ignored
      wr(8'h01);
      wr(8'h02);
      step();
      check("R6", "write in busy", rd_data, 8'h00);

      // R5 lock
      lock = 1'b1;
      wr(8'h42);
      lock = 1'b0;
      check("R5", "locked write", rd_data, 8'h00);

      // R7 continuous analog power
      inp_sel = 1'b1;
      wr(8'h02);
      step();
      check("R7", "ana on", ana_en, 1);
      inp_sel = 1'b0;
      step();
      check("R7", "ana off", ana_en, 0);

      // R9 start strobe, R10 trigger during conversion
      trig = 1'b1; step(); trig = 1'b0;
      check("R9", "start", conv_start, 1);
      step();
      check("R9", "start pulse end", conv_start, 0);
      trig = 1'b1; step(); trig = 1'b0;
      check("R10", "busy trig", conv_start, 0);
      conv_done = 1'b1; step(); conv_done = 1'b0;

      // R10 disabled trigger
      wr(8'h00);
      trig = 1'b1; step(); trig = 1'b0;
      check("R10", "disabled trig", conv_start, 0);

      // R8 on-demand power
      inp_sel = 1'b1;
      wr(8'h82);
      step();
      check("R8", "ana idle", ana_en, 0);
      trig = 1'b1; step(); trig = 1'b0;
      check("R8", "ana rise", {ana_en, conv_start}, 2'b10);
      for (int i = 1; i < SETTLE; i++) begin
         step();
         check("R8", "settle wait", conv_start, 0);
      end
      step();
      check("R8", "start after settle", {ana_en, conv_start}, 2'b11);
      step();
      check("R8", "start single", {ana_en, conv_start}, 2'b10);
      conv_done = 1'b1; step(); conv_done = 1'b0;
      check("R8", "ana fall", ana_en, 0);
      inp_sel = 1'b0;

      // R11 standby waits for conversion
      wr(8'h02);
      trig = 1'b1; step(); trig = 1'b0;
      stby_req = 1'b1; step();
      check("R11", "ack held", stby_ack, 0);
      conv_done = 1'b1; step(); conv_done = 1'b0;
      check("R11", "ack after done", stby_ack, 1);
      trig = 1'b1; step(); trig = 1'b0;
      check("R11", "trig blocked", conv_start, 0);
      stby_req = 1'b0; step();

      // R12 running in standby
      wr(8'h42);
      stby_req = 1'b1; step();
      check("R12", "ack", {stby_ack, clk_req}, 2'b10);
      trig = 1'b1; step(); trig = 1'b0;
      check("R12", "clk req + start", {clk_req, conv_start}, 2'b11);
      step();
      check("R12", "clk req held", clk_req, 1);
      conv_done = 1'b1; step(); conv_done = 1'b0;
      check("R12", "clk req drop", clk_req, 0);
      stby_req = 1'b0; step();

      // random register traffic, R2 R4 R5 R6 R7
      wr(8'h01); step(); step();
      mf = 8'h00; bcnt = 0;
      for (int i = 0; i < 400; i++) begin
         logic w, l, s, q;
         logic [7:0] d;
         logic ea;
         w = 1'($urandom); l = 1'($urandom_range(0, 3) == 0);
         s = 1'($urandom); q = 1'($urandom);
         d = 8'($urandom);
         if ($urandom_range(0, 7) == 0) d[0] = 1'b1; else d[0] = 1'b0;
         wr_en = w; lock = l; wr_data = d; inp_sel = s; stby_req = q;
         ea = !mf[7] && mf[1] && s;
         if (bcnt != 0) bcnt--;
         else if (w && !l) begin
            if (d[0]) begin mf = 8'h00; bcnt = SRST; end
            else mf = d & 8'hC2;
         end
         step();
         check("R2", "rand read", rd_data, exp_read(mf, bcnt != 0));
         check("R7", "rand ana", ana_en, ea);
         check("R12", "rand ack", stby_ack, q);
      end
      wr_en = 1'b0; lock = 1'b0; inp_sel = 1'b0; stby_req = 1'b0;
      step();
      finish_run();
   end
endmodule